// File: doc/BRIEF.md
# Quad-Lane Serial Flash Command Sequencer

This block runs one serial flash command at a time on a four-line bus. Software programs a command word, an address word, a data length and a clock divider through a small register write port. The block then drives chip select, the serial clock and up to four IO lanes through four phases, in this order: instruction, address, dummy cycles and data. Each phase has its own lane-width code and is skipped when that code (or the dummy count) is zero.

Write data is taken one byte at a time from an external FIFO through a pop strobe. Read data is assembled from the input lanes and pushed one byte at a time into an external FIFO. When the FIFO cannot serve a byte, the block stalls with the serial clock low. Completion and error are sticky flags that software clears by writing ones to a separate clear register. A busy output marks the transfer. A control bit aborts the transfer; the hardware then clears that bit by itself.

Top module: `qspi_cmd_seq`

## Requirements
- R1: After reset, chip select (`cs_n`) is high, `sck` is low, all lane enables are low, and `busy`, `flag_tc`, `flag_te` and `abort_active` are all low.
- R2: Register selects are 0 control, 1 command, 2 address, 3 length and 4 flag clear. The command word fields are: instruction in 7:0, instruction lane code in 9:8, address lane code in 11:10, address size in 13:12, dummy count in 22:18, data lane code in 25:24 and functional mode in 27:26. If the address lane code is zero, writing the command starts the transfer. If it is nonzero, the transfer starts only when the address register is written.
- R3: Lane code 0 skips a phase, 1 uses one line (output on IO0, input on IO1), 2 uses IO1:0 and 3 uses IO3:0. Each rising `sck` carries the next most significant bits of the phase, and the lane enables are set only for lanes that are driven.
- R4: The address phase sends (size field + 1) bytes, taken from the low end of the address word and sent most significant byte first.
- R5: The dummy phase lasts exactly the programmed number of serial clock cycles with no lane driven. A count of zero skips it.
- R6: The length register holds the byte count minus one. In functional mode 0, the data phase pops one FIFO byte per byte sent. In mode 1, it pushes one assembled byte per byte received.
- R7: One serial clock cycle lasts P+1 kernel clocks, where P is control bits 31:24 (a value of 0 acts as 1). The transfer lasts the sum of the phase cycles times (P+1) plus one extra kernel clock for each data byte.
- R8: When a data byte is due and the write FIFO is empty, or the read FIFO is full, the block holds `sck` low and keeps chip select asserted until the FIFO is ready.
- R9: Chip select is low and `busy` is high for the whole transfer. Both return to idle when it ends. While chip select is high, `sck` and all lane enables are low.
- R10: The completion flag sets when the last phase ends and stays set until a register-4 write with bit 1 set. When a set and a clear fall in the same clock, the flag is set.
- R11: A start request with functional mode 2 or 3 sets the error flag and starts no transfer. A register-4 write with bit 0 set clears the error flag.
- R12: Writing control bit 1 raises `abort_active`. On the next clock the transfer stops, chip select rises and `abort_active` clears by itself. No completion flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Kernel clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select |
| reg_wdata | input | 32 | Register write data |
| busy | output | 1 | Transfer in progress |
| flag_tc | output | 1 | Sticky completion flag |
| flag_te | output | 1 | Sticky error flag |
| abort_active | output | 1 | Abort request pending (self-clearing) |
| sck | output | 1 | Serial clock, idles low |
| cs_n | output | 1 | Chip select, active low |
| io_out | output | 4 | Lane output values |
| io_oe | output | 4 | Lane output enables |
| io_in | input | 4 | Lane input values |
| fifo_pop | output | 1 | Take one byte from the write FIFO |
| fifo_rd_data | input | 8 | Head byte of the write FIFO |
| fifo_empty | input | 1 | Write FIFO empty |
| fifo_push | output | 1 | Store one byte into the read FIFO |
| fifo_wr_data | output | 8 | Byte to store |
| fifo_full | input | 1 | Read FIFO full |

## Verification
Two events can land on the same clock edge: the hardware setting the completion flag as the final phase ends, and a software write-one-to-clear of that flag. The bench computes the exact transfer length from the phase counts and the divider. It then times the clear write to be sampled on that final edge, and requires the flag to read as set afterwards. A later clear, with no set pending, must drop the flag. A second pairing is an abort landing during a transfer: it must leave no completion flag behind.

// File: rtl/qspi_cmd_seq.sv
module qspi_cmd_seq #(
  parameter int LENW = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [2:0]  reg_sel,
  input  logic [31:0] reg_wdata,
  output logic        busy,
  output logic        flag_tc,
  output logic        flag_te,
  output logic        abort_active,
  output logic        sck,
  output logic        cs_n,
  output logic [3:0]  io_out,
  output logic [3:0]  io_oe,
  input  logic [3:0]  io_in,
  output logic        fifo_pop,
  input  logic [7:0]  fifo_rd_data,
  input  logic        fifo_empty,
  output logic        fifo_push,
  output logic [7:0]  fifo_wr_data,
  input  logic        fifo_full
);
  localparam logic [2:0] P_IDLE = 3'd0, P_INS = 3'd1, P_ADR = 3'd2, P_DUM = 3'd3, P_DAT = 3'd4;

  logic [7:0]      presc, cnt, cyc, rx, rx_nxt;
  logic [31:0]     cmd, addr, sr, sr_sh;
  logic [LENW-1:0] dlen, left;
  logic [2:0]      ph;
  logic [1:0]      code;
  logic            abort_q, ld;

  function automatic logic [7:0] ncyc(input logic [1:0] c, input logic [7:0] bits);
    case (c)
      2'd1:    return bits;
      2'd2:    return bits >> 1;
      default: return bits >> 2;
    endcase
  endfunction

  function automatic logic [2:0] nxt(input logic [2:0] p, input logic [31:0] c);
    if (p < P_INS && c[9:8] != 2'd0)        return P_INS;
    else if (p < P_ADR && c[11:10] != 2'd0) return P_ADR;
    else if (p < P_DUM && c[22:18] != 5'd0) return P_DUM;
    else if (p < P_DAT && c[25:24] != 2'd0) return P_DAT;
    else                                    return P_IDLE;
  endfunction

  wire        wr_ctl = reg_we && reg_sel == 3'd0;
  wire        wr_cmd = reg_we && reg_sel == 3'd1;
  wire        wr_adr = reg_we && reg_sel == 3'd2;
  wire        wr_clr = reg_we && reg_sel == 3'd4;
  wire [31:0] scmd   = wr_cmd ? reg_wdata : cmd;
  wire [31:0] saddr  = wr_adr ? reg_wdata : addr;
  wire        trig   = !busy && ((wr_cmd && reg_wdata[11:10] == 2'd0) ||
                                 (wr_adr && cmd[11:10] != 2'd0));
  wire        bad    = trig && scmd[27];
  wire        start  = trig && !scmd[27] && !abort_q;
  wire [7:0]  pe     = (presc == 8'd0) ? 8'd1 : presc;
  wire        wr_dir = cmd[27:26] == 2'd0;
  wire        run    = ph != P_IDLE && !ld;
  wire        tick   = run && cnt == pe;
  wire        uend   = tick && cyc == 8'd1;
  wire        more   = ph == P_DAT && left != '0;
  wire        adv    = start || (uend && !more);
  wire [31:0] ec     = start ? scmd : cmd;
  wire [2:0]  eph    = nxt(start ? P_IDLE : ph, ec);
  wire        bok    = wr_dir ? !fifo_empty : !fifo_full;
  wire        drv    = ph == P_INS || ph == P_ADR || (ph == P_DAT && wr_dir);
  wire [4:0]  ash    = {2'd3 - ec[13:12], 3'b000};
  wire [7:0]  abits  = {2'b00, 3'd1 + {1'b0, ec[13:12]}, 3'b000};

  always_comb begin
    case (ph)
      P_INS:   code = cmd[9:8];
      P_ADR:   code = cmd[11:10];
      P_DAT:   code = cmd[25:24];
      default: code = 2'd1;
    endcase
    case (code)
      2'd1:    begin rx_nxt = {rx[6:0], io_in[1]};   sr_sh = sr << 1; end
      2'd2:    begin rx_nxt = {rx[5:0], io_in[1:0]}; sr_sh = sr << 2; end
      default: begin rx_nxt = {rx[3:0], io_in};      sr_sh = sr << 4; end
    endcase
  end

  assign busy         = ph != P_IDLE;
  assign cs_n         = ph == P_IDLE;
  assign abort_active = abort_q;
  assign sck          = run && ({1'b0, cnt} >= (({1'b0, pe} + 9'd1) >> 1));
  assign io_oe        = !drv ? 4'b0000 : code == 2'd1 ? 4'b0001 : code == 2'd2 ? 4'b0011 : 4'b1111;
  assign io_out       = !drv ? 4'b0000 : code == 2'd1 ? {3'b000, sr[31]} :
                        code == 2'd2 ? {2'b00, sr[31:30]} : sr[31:28];
  assign fifo_pop     = ph == P_DAT && ld && wr_dir && !fifo_empty && !abort_q;
  assign fifo_push    = ph == P_DAT && !wr_dir && uend && !abort_q;
  assign fifo_wr_data = rx_nxt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      presc <= '0; abort_q <= 1'b0; cmd <= '0; addr <= '0; dlen <= '0;
      flag_tc <= 1'b0; flag_te <= 1'b0;
      ph <= P_IDLE; cnt <= '0; cyc <= '0; sr <= '0; rx <= '0; left <= '0; ld <= 1'b0;
    end else begin
      if (wr_ctl) presc <= reg_wdata[31:24];
      if (wr_cmd && !busy) cmd <= reg_wdata;
      if (wr_adr && !busy) addr <= reg_wdata;
      if (reg_we && reg_sel == 3'd3 && !busy) dlen <= reg_wdata[LENW-1:0];
      abort_q <= !abort_q && wr_ctl && reg_wdata[1];
      flag_tc <= (flag_tc && !(wr_clr && reg_wdata[1])) || (adv && eph == P_IDLE && !abort_q);
      flag_te <= (flag_te && !(wr_clr && reg_wdata[0])) || bad;
      if (abort_q) begin
        ph <= P_IDLE; ld <= 1'b0; cnt <= '0;
      end else if (adv) begin
        ph <= eph; cnt <= '0; ld <= 1'b0;
        case (eph)
          P_INS: begin sr <= {ec[7:0], 24'd0}; cyc <= ncyc(ec[9:8], 8'd8); end
          P_ADR: begin sr <= saddr << ash; cyc <= ncyc(ec[11:10], abits); end
          P_DUM: cyc <= {3'b000, ec[22:18]};
          P_DAT: begin ld <= 1'b1; left <= dlen; cyc <= ncyc(ec[25:24], 8'd8); end
          default: ;
        endcase
      end else if (ld) begin
        if (bok) begin
          ld <= 1'b0;
          if (wr_dir) sr <= {fifo_rd_data, 24'd0};
        end
      end else if (tick) begin
        cnt <= '0;
        rx  <= rx_nxt;
        if (cyc != 8'd1) begin
          cyc <= cyc - 8'd1;
          sr  <= sr_sh;
        end else begin
          ld   <= 1'b1;
          left <= left - 1'b1;
          cyc  <= ncyc(code, 8'd8);
        end
      end else if (ph != P_IDLE) begin
        cnt <= cnt + 8'd1;
      end
    end
  end
endmodule

// File: rtl/qspi_cmd_seq_chk.sv
module qspi_cmd_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_we,
  input logic [2:0]  reg_sel,
  input logic [31:0] reg_wdata,
  input logic        flag_tc,
  input logic        flag_te,
  input logic        abort_active,
  input logic        sck,
  input logic        cs_n,
  input logic [3:0]  io_oe,
  input logic        fifo_pop,
  input logic        fifo_push
);
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> (!sck && io_oe == 4'b0000)); // R9
  AST_ABORT_SELFCLR: assert property (@(posedge clk) disable iff (!rst_n)
    abort_active |=> (!abort_active && cs_n)); // R12
  AST_TC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_tc && !(reg_we && reg_sel == 3'd4 && reg_wdata[1])) |=> flag_tc); // R10
  AST_LANE_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (io_oe == 4'b0000 || io_oe == 4'b0001 || io_oe == 4'b0011 || io_oe == 4'b1111)); // R3
  AST_TE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_te) |-> cs_n); // R11
  AST_FIFO_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_pop || fifo_push) |-> !cs_n); // R6
endmodule

bind qspi_cmd_seq qspi_cmd_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
  .flag_tc(flag_tc), .flag_te(flag_te), .abort_active(abort_active), .sck(sck),
  .cs_n(cs_n), .io_oe(io_oe), .fifo_pop(fifo_pop), .fifo_push(fifo_push)
);

// File: tb/sim_qspi_cmd_seq.sv
`timescale 1ns/1ps
module sim_qspi_cmd_seq;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_sel = 3'd0;
  logic [31:0] reg_wdata = 32'd0;
  logic        busy, flag_tc, flag_te, abort_active, sck, cs_n, fifo_pop, fifo_push;
  logic [3:0]  io_out, io_oe;
  logic [3:0]  io_in = 4'd0;
  logic [7:0]  fifo_rd_data, fifo_wr_data;
  logic        fifo_empty, fifo_full_r = 1'b0;

  int nchk = 0, nfail = 0;
  bit done = 1'b0;

  logic [7:0]  wq [0:63];
  logic [7:0]  rq [0:255];
  logic [3:0]  rec_oe [0:1023];
  logic [3:0]  rec_v  [0:1023];
  logic [3:0]  vin    [0:1023];
  logic [3:0]  exp_oe [0:255];
  logic [3:0]  exp_v  [0:255];
  int unsigned rd_ptr = 0, rd_base = 0, avail = 0, pcnt = 0, nsc = 0, ne = 0;
  logic sck_d = 1'b0;

  always #2 clk = ~clk;

  assign fifo_empty   = (rd_ptr - rd_base) >= avail;
  assign fifo_rd_data = wq[6'(rd_ptr - rd_base)];

  qspi_cmd_seq u0 (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .busy(busy), .flag_tc(flag_tc), .flag_te(flag_te), .abort_active(abort_active),
    .sck(sck), .cs_n(cs_n), .io_out(io_out), .io_oe(io_oe), .io_in(io_in),
    .fifo_pop(fifo_pop), .fifo_rd_data(fifo_rd_data), .fifo_empty(fifo_empty),
    .fifo_push(fifo_push), .fifo_wr_data(fifo_wr_data), .fifo_full(fifo_full_r)
  );

  always @(posedge clk) begin
    if (fifo_pop) rd_ptr <= rd_ptr + 1;
    if (fifo_push) begin
      rq[pcnt[7:0]] <= fifo_wr_data;
      pcnt <= pcnt + 1;
    end
  end

  always @(negedge clk) begin
    if (sck && !sck_d) begin
      logic [3:0] v;
      v = 4'($urandom);
      rec_oe[nsc[9:0]] <= io_oe;
      rec_v[nsc[9:0]]  <= io_out & io_oe;
      vin[nsc[9:0]]    <= v;
      io_in <= v;
      nsc <= nsc + 1;
    end
    sck_d <= sck;
  end

  task automatic chk(input string req, input longint act, input longint expv);
    nchk++;
    if (act != expv) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic wr(input logic [2:0] s, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = s; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  function automatic int bpc(input logic [1:0] c);
    return (c == 2'd3) ? 4 : (c == 2'd2) ? 2 : 1;
  endfunction

  task automatic put(input logic [1:0] c, input int n, input logic [31:0] v, input bit drv);
    logic [31:0] s = v;
    for (int i = 0; i < n; i++) begin
      if (!drv) begin exp_oe[ne] = 4'd0; exp_v[ne] = 4'd0; end
      else if (c == 2'd1) begin exp_oe[ne] = 4'b0001; exp_v[ne] = {3'b000, s[31]}; end
      else if (c == 2'd2) begin exp_oe[ne] = 4'b0011; exp_v[ne] = {2'b00, s[31:30]}; end
      else begin exp_oe[ne] = 4'b1111; exp_v[ne] = s[31:28]; end
      s = s << bpc(c);
      ne++;
    end
  endtask

  task automatic run_txn(input logic [1:0] im, input logic [1:0] am, input logic [1:0] asz,
                         input logic [4:0] dc, input logic [1:0] dm, input int dl,
                         input logic [1:0] fm, input logic [7:0] pr, input bit hold);
    logic [7:0]  inst = 8'($urandom);
    logic [31:0] ad   = $urandom;
    logic [31:0] cw;
    int pe, t, te_exp, pre, sb, pb, mis, cpb;
    logic [7:0] b;
    cw = {4'h0, fm, dm, 1'b0, dc, 4'h0, asz, am, im, inst};
    for (int j = 0; j <= dl; j++) wq[j] = 8'($urandom);
    pe = (pr == 8'd0) ? 1 : int'(pr);
    ne = 0; te_exp = 0;
    if (im != 0) begin put(im, 8 / bpc(im), {inst, 24'd0}, 1'b1); te_exp += (8 / bpc(im)) * (pe + 1); end
    if (am != 0) begin
      put(am, 8 * (asz + 1) / bpc(am), ad << (8 * (3 - asz)), 1'b1);
      te_exp += (8 * (asz + 1) / bpc(am)) * (pe + 1);
    end
    if (dc != 0) begin put(2'd1, int'(dc), 32'd0, 1'b0); te_exp += int'(dc) * (pe + 1); end
    pre = ne;
    cpb = 8 / bpc(dm);
    if (dm != 0) begin
      for (int j = 0; j <= dl; j++) put(dm, cpb, {wq[j], 24'd0}, fm == 2'd0);
      te_exp += (dl + 1) * (1 + cpb * (pe + 1));
    end
    wr(3'd0, {pr, 24'd0});
    wr(3'd4, 32'd3);
    wr(3'd3, 32'(dl));
    rd_base = rd_ptr; pb = int'(pcnt); sb = int'(nsc);
    avail = hold ? 0 : dl + 1;
    fifo_full_r = hold && fm == 2'd1;
    wr(3'd1, cw);
    if (am != 0) begin
      chk("R2 no start on command write with address phase", busy, 0);
      wr(3'd2, ad);
    end
    if (hold) begin
      repeat (60) @(negedge clk);
      chk("R8 stalled busy", busy, 1);
      chk("R8 serial cycles before stalled data", int'(nsc) - sb, pre);
      avail = dl + 1;
      fifo_full_r = 1'b0;
    end
    t = 0;
    while (busy && t < 5000) begin t++; @(negedge clk); end
    if (!hold) chk("R7 transfer length in kernel clocks", t, te_exp);
    chk("R10 completion flag", flag_tc, 1);
    chk("R9 chip select released", cs_n, 1);
    chk("R3 serial cycle count", int'(nsc) - sb, ne);
    mis = 0;
    for (int k = 0; k < ne; k++) begin
      if (rec_oe[10'(sb + k)] != exp_oe[k] || rec_v[10'(sb + k)] != exp_v[k]) mis++;
    end
    chk("R3 R4 R5 lane contents", mis, 0);
    if (dm != 0 && fm == 2'd0) chk("R6 bytes popped", int'(rd_ptr - rd_base), dl + 1);
    if (dm != 0 && fm == 2'd1) begin
      chk("R6 bytes pushed", int'(pcnt) - pb, dl + 1);
      mis = 0;
      for (int j = 0; j <= dl; j++) begin
        b = 8'd0;
        for (int k = 0; k < cpb; k++) begin
          logic [3:0] v;
          v = vin[10'(sb + pre + j * cpb + k)];
          if (dm == 2'd1) b = {b[6:0], v[1]};
          else if (dm == 2'd2) b = {b[5:0], v[1:0]};
          else b = {b[3:0], v};
        end
        if (rq[8'(pb + j)] != b) mis++;
      end
      chk("R6 read bytes", mis, 0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1f2e3d4c));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 busy", busy, 0);
    chk("R1 cs_n", cs_n, 1);
    chk("R1 sck", sck, 0);
    chk("R1 io_oe", io_oe, 0);
    chk("R1 flags", {flag_tc, flag_te, abort_active}, 0);

    run_txn(2'd1, 2'd1, 2'd2, 5'd0, 2'd1, 1, 2'd0, 8'd1, 1'b0);
    run_txn(2'd3, 2'd3, 2'd3, 5'd6, 2'd3, 3, 2'd1, 8'd0, 1'b0);
    run_txn(2'd2, 2'd0, 2'd0, 5'd31, 2'd2, 2, 2'd1, 8'd3, 1'b0);
    run_txn(2'd0, 2'd0, 2'd0, 5'd0, 2'd0, 0, 2'd0, 8'd2, 1'b0);
    run_txn(2'd1, 2'd0, 2'd0, 5'd0, 2'd1, 1, 2'd0, 8'd1, 1'b1);
    run_txn(2'd1, 2'd2, 2'd0, 5'd2, 2'd3, 0, 2'd1, 8'd2, 1'b1);

    for (int n = 0; n < 40; n++) begin
      logic [4:0] dc;
      dc = 5'($urandom % 8);
      if ($urandom % 8 == 0) dc = 5'd31;
      run_txn(2'($urandom), 2'($urandom), 2'($urandom), dc, 2'($urandom),
              int'($urandom % 6), 2'($urandom % 2), 8'($urandom % 4), 1'b0);
    end

    // R10 set and clear in the same clock: set wins
    wr(3'd0, {8'd1, 24'd0});
    wr(3'd4, 32'd3);
    wr(3'd1, {4'h0, 2'd0, 2'd0, 1'b0, 5'd0, 4'h0, 2'd0, 2'd0, 2'd1, 8'h9f});
    repeat (15) @(negedge clk);
    reg_we = 1'b1; reg_sel = 3'd4; reg_wdata = 32'd2;
    @(negedge clk);
    reg_we = 1'b0;
    chk("R10 set wins over clear", flag_tc, 1);
    chk("R9 idle after collision", busy, 0);
    wr(3'd4, 32'd2);
    chk("R10 clear", flag_tc, 0);

    // R12 abort mid-transfer
    wr(3'd0, {8'd3, 24'd0});
    wr(3'd3, 32'd4);
    rd_base = rd_ptr; avail = 5;
    wr(3'd1, {4'h0, 2'd0, 2'd1, 1'b0, 5'd0, 4'h0, 2'd3, 2'd1, 2'd3, 8'h38});
    wr(3'd2, 32'h00a5a5a5);
    repeat (10) @(negedge clk);
    wr(3'd0, {8'd3, 22'd0, 2'b10});
    chk("R12 abort raised", abort_active, 1);
    @(negedge clk);
    chk("R12 abort self-cleared", abort_active, 0);
    chk("R12 chip select high", cs_n, 1);
    chk("R12 busy low", busy, 0);
    chk("R12 no completion", flag_tc, 0);
    chk("R12 sck low", sck, 0);

    // R11 error on unsupported functional modes
    wr(3'd1, {4'h0, 2'd2, 2'd0, 1'b0, 5'd0, 4'h0, 2'd0, 2'd0, 2'd1, 8'h05});
    chk("R11 error flag", flag_te, 1);
    chk("R11 no transfer", busy, 0);
    wr(3'd1, {4'h0, 2'd3, 2'd0, 1'b0, 5'd0, 4'h0, 2'd0, 2'd1, 2'd1, 8'h0b});
    wr(3'd2, 32'h1234);
    chk("R11 no transfer via address trigger", cs_n, 1);
    wr(3'd4, 32'd1);
    chk("R11 error cleared", flag_te, 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule